// File: doc/BRIEF.md
# Permission-Aware Set-Associative Tag Directory

This block holds the tag side of a set-associative cache. For every way of every set it stores whether the way is in use, the full line address, an access permission and an optional lock owner. It performs no data storage, coherence or replacement choice of its own. A controller sends one command per cycle. Each command gets a registered response one cycle later, marked by a valid strobe. The response carries the hit flag, a way number, the room flag, a victim address and an error flag.

Replacement is kept outside the block. When an access matches a line, and optionally when a line is allocated, the directory sends a touch pulse that names the set and the way. For a victim probe it shows the set it is working on, on a combinational output. The external policy answers in the same cycle with the way to evict. The set index is a contiguous field of the line address. It starts at bit `IDX_LSB` and is log2(`SETS`) bits wide. Addresses must be line-aligned.

The command decode is one `unique case` over the opcode. Each opcode plays the part of a state: ACCESS, LOOKUP, PEEK, AVAIL, ALLOC, DEALLOC, VICTIM, LOCK_SET, LOCK_CLR, LOCK_TEST and SET_PERM. Any other opcode, and any misaligned address, takes the REJECT branch. The block holds no sequencing state apart from the line store and the response register.

Top module: `perm_tag_dir`

## Requirements
- R1: After reset every way is empty and has no lock owner, and rsp_valid and touch_valid are 0. LOOKUP therefore misses in every set, AVAIL reports room and VICTIM is rejected.
- R2: A command is rejected when its address has a nonzero offset (bits [OFF_W-1:0]) or its opcode is not in 0..10. The response then has rsp_err=1 and every other field 0, the store does not change and no touch is sent.
- R3: The set index is cmd_addr[IDX_LSB +: log2(SETS)]. Addresses that differ only in that field go to separate, independent sets.
- R4: ACCESS (op 0) hits when the lowest matching present way has permission read-write (3). It also hits with read-only (2), but only for request type load (0) or fetch (1). Store (2) to a read-only line, and any access to invalid (1) or busy (4), is a miss. The permission codes are absent=0, invalid=1, read-only=2, read-write=3, busy=4.
- R5: Any ACCESS that matches a present line gives touch_valid=1, with touch_set and touch_way naming that line, whether or not it hits. A miss gives no touch, and the touch fields are 0 when touch_valid is 0.
- R6: A way is present when it is in use, its address equals cmd_addr and its permission is not absent (0). LOOKUP (op 1) reports present. PEEK (op 2) reports any in-use address match, whatever the permission. rsp_way gives the lowest matching way.
- R7: AVAIL (op 3) sets rsp_avail when the set has an in-use way holding cmd_addr, an empty way, or a way with permission absent.
- R8: A legal ALLOC (op 4) fills the lowest way that is empty or absent and returns that way. It stores the address with permission invalid and no lock owner. It sends a touch only when cmd_touch=1.
- R9: ALLOC is rejected with rsp_err when the address is already present, or when the set has no room.
- R10: DEALLOC (op 5) of a present address empties its way and returns the way number. DEALLOC of an address that is not present is rejected.
- R11: VICTIM (op 6) exposes the set on pol_set and returns the address stored in the way given by pol_victim_way, together with that way number. It is rejected when the set has room.
- R12: LOCK_SET (op 7) records cmd_ctx as the owner of a present line, and LOCK_CLR (op 8) removes the owner. LOCK_TEST (op 9) hits only when an owner is recorded and it equals cmd_ctx. All three are rejected when the line is not present.
- R13: SET_PERM (op 10) writes cmd_perm into the lowest in-use way whose address matches, whatever its current permission. It is rejected when no way matches or when cmd_perm is above 4.
- R14: rsp_valid is 1 exactly in the cycle after a cycle with cmd_valid=1. Fields not defined for the opcode read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 4 | Opcode 0..10 |
| cmd_addr | input | ADDR_W | Line address |
| cmd_req | input | 2 | Access type: 0 load, 1 fetch, 2 store |
| cmd_touch | input | 1 | ALLOC sends a touch |
| cmd_ctx | input | CTX_W | Lock context |
| cmd_perm | input | 3 | Permission for SET_PERM |
| pol_set | output | SET_W | Set of the current command, for the policy |
| pol_victim_way | input | WAY_W | Victim way chosen by the policy |
| rsp_valid | output | 1 | Response strobe |
| rsp_err | output | 1 | Command rejected |
| rsp_hit | output | 1 | Hit / present / lock match |
| rsp_way | output | WAY_W | Way concerned |
| rsp_avail | output | 1 | Set has room (AVAIL) |
| rsp_victim_addr | output | ADDR_W | Victim line address |
| touch_valid | output | 1 | Touch pulse to the policy |
| touch_set | output | SET_W | Touched set |
| touch_way | output | WAY_W | Touched way |

## Verification
The assertions assume that pol_victim_way is settled in the command cycle and names an existing way. They also assume that cmd_op and cmd_addr are stable and known whenever cmd_valid is high. The stimulus drives its commands half a cycle ahead of the capturing edge. A small fixed policy in the bench returns set+1 modulo the way count as the victim, so every victim way is in range. Several lines may carry the same address, for example when an absent line is reused. The bench only allocates over an absent line after that line's own address has gone, so the lowest-way rule never has to tell duplicate tags apart.

// File: rtl/tagdir_pkg.sv
package tagdir_pkg;

    typedef enum logic [2:0] {
        PERM_ABSENT = 3'd0,
        PERM_INVAL  = 3'd1,
        PERM_RDONLY = 3'd2,
        PERM_RDWR   = 3'd3,
        PERM_BUSY   = 3'd4
    } perm_e;

    typedef enum logic [3:0] {
        OP_ACCESS    = 4'd0,
        OP_LOOKUP    = 4'd1,
        OP_PEEK      = 4'd2,
        OP_AVAIL     = 4'd3,
        OP_ALLOC     = 4'd4,
        OP_DEALLOC   = 4'd5,
        OP_VICTIM    = 4'd6,
        OP_LOCK_SET  = 4'd7,
        OP_LOCK_CLR  = 4'd8,
        OP_LOCK_TEST = 4'd9,
        OP_SET_PERM  = 4'd10
    } op_e;

    localparam logic [1:0] REQ_LOAD   = 2'd0;
    localparam logic [1:0] REQ_IFETCH = 2'd1;
    localparam logic [1:0] REQ_STORE  = 2'd2;

endpackage

// File: rtl/tagdir_way_cmp.sv
module tagdir_way_cmp
    import tagdir_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              used,
    input  logic [ADDR_W-1:0] line_addr,
    input  perm_e             perm,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              tag_eq,
    output logic              present,
    output logic              free
);
    // tag_eq ignores permission; present requires a non-absent line
    always_comb begin
        tag_eq  = used && (line_addr == req_addr);
        present = tag_eq && (perm != PERM_ABSENT);
        free    = !used || (perm == PERM_ABSENT);
    end
endmodule

// File: rtl/tagdir_first_one.sv
module tagdir_first_one #(
    parameter int N = 4,
    parameter int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0] vec,
    output logic         found,
    output logic [W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = W'(i);
            end
        end
    end
endmodule

// File: rtl/perm_tag_dir.sv
module perm_tag_dir
    import tagdir_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int OFF_W   = 4,
    parameter int SETS    = 4,
    parameter int WAYS    = 4,
    parameter int IDX_LSB = 4,
    parameter int CTX_W   = 4,
    parameter int SET_W   = $clog2(SETS),
    parameter int WAY_W   = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [3:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [1:0]        cmd_req,
    input  logic              cmd_touch,
    input  logic [CTX_W-1:0]  cmd_ctx,
    input  logic [2:0]        cmd_perm,
    output logic [SET_W-1:0]  pol_set,
    input  logic [WAY_W-1:0]  pol_victim_way,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic              rsp_hit,
    output logic [WAY_W-1:0]  rsp_way,
    output logic              rsp_avail,
    output logic [ADDR_W-1:0] rsp_victim_addr,
    output logic              touch_valid,
    output logic [SET_W-1:0]  touch_set,
    output logic [WAY_W-1:0]  touch_way
);

    // ---------------- line store ----------------
    logic [WAYS-1:0]   line_vld  [SETS];
    logic [ADDR_W-1:0] line_addr [SETS][WAYS];
    perm_e             line_perm [SETS][WAYS];
    logic [WAYS-1:0]   lk_vld    [SETS];
    logic [CTX_W-1:0]  lk_ctx    [SETS][WAYS];

    // ---------------- command decode ----------------
    op_e              op;
    logic [SET_W-1:0] cset;
    logic             misaligned;

    assign op         = op_e'(cmd_op);
    assign cset       = cmd_addr[IDX_LSB +: SET_W];
    assign misaligned = |cmd_addr[OFF_W-1:0];
    assign pol_set    = cset;

    // ---------------- per-way compare ----------------
    logic [WAYS-1:0] eq_vec, pres_vec, free_vec;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        tagdir_way_cmp #(.ADDR_W(ADDR_W)) u_cmp (
            .used      (line_vld[cset][w]),
            .line_addr (line_addr[cset][w]),
            .perm      (line_perm[cset][w]),
            .req_addr  (cmd_addr),
            .tag_eq    (eq_vec[w]),
            .present   (pres_vec[w]),
            .free      (free_vec[w])
        );
    end

    logic             pres_found, eq_found, free_found;
    logic [WAY_W-1:0] pres_idx, eq_idx, free_idx;

    tagdir_first_one #(.N(WAYS), .W(WAY_W)) u_pres (
        .vec(pres_vec), .found(pres_found), .idx(pres_idx));
    tagdir_first_one #(.N(WAYS), .W(WAY_W)) u_eq (
        .vec(eq_vec),   .found(eq_found),   .idx(eq_idx));
    tagdir_first_one #(.N(WAYS), .W(WAY_W)) u_free (
        .vec(free_vec), .found(free_found), .idx(free_idx));

    logic  set_avail;
    perm_e pres_perm;
    assign set_avail = eq_found || free_found;
    assign pres_perm = line_perm[cset][pres_idx];

    // ---------------- next response and write controls ----------------
    logic              nx_hit, nx_avail, nx_err, nx_touch;
    logic [WAY_W-1:0]  nx_way, nx_tway;
    logic [ADDR_W-1:0] nx_vaddr;
    logic              wr_alloc, wr_dealloc, wr_lkset, wr_lkclr, wr_perm;
    logic [WAY_W-1:0]  wr_way;

    always_comb begin
        nx_hit     = 1'b0;
        nx_avail   = 1'b0;
        nx_err     = 1'b0;
        nx_touch   = 1'b0;
        nx_way     = '0;
        nx_tway    = '0;
        nx_vaddr   = '0;
        wr_alloc   = 1'b0;
        wr_dealloc = 1'b0;
        wr_lkset   = 1'b0;
        wr_lkclr   = 1'b0;
        wr_perm    = 1'b0;
        wr_way     = '0;
        if (cmd_valid) begin
            if (misaligned) begin
                nx_err = 1'b1;                         // REJECT
            end else begin
                unique case (op)
                    OP_ACCESS: begin
                        nx_hit = pres_found &&
                                 ((pres_perm == PERM_RDWR) ||
                                  ((pres_perm == PERM_RDONLY) &&
                                   ((cmd_req == REQ_LOAD) || (cmd_req == REQ_IFETCH))));
                        nx_way   = pres_idx;
                        nx_touch = pres_found;
                        nx_tway  = pres_idx;
                    end
                    OP_LOOKUP: begin
                        nx_hit = pres_found;
                        nx_way = pres_idx;
                    end
                    OP_PEEK: begin
                        nx_hit = eq_found;
                        nx_way = eq_idx;
                    end
                    OP_AVAIL: begin
                        nx_avail = set_avail;
                    end
                    OP_ALLOC: begin
                        if (pres_found || !set_avail) begin
                            nx_err = 1'b1;
                        end else begin
                            wr_alloc = 1'b1;
                            wr_way   = free_idx;
                            nx_way   = free_idx;
                            nx_touch = cmd_touch;
                            nx_tway  = cmd_touch ? free_idx : '0;
                        end
                    end
                    OP_DEALLOC: begin
                        if (!pres_found) nx_err = 1'b1;
                        else begin
                            wr_dealloc = 1'b1;
                            wr_way     = pres_idx;
                            nx_way     = pres_idx;
                        end
                    end
                    OP_VICTIM: begin
                        if (set_avail) nx_err = 1'b1;
                        else begin
                            nx_vaddr = line_addr[cset][pol_victim_way];
                            nx_way   = pol_victim_way;
                        end
                    end
                    OP_LOCK_SET, OP_LOCK_CLR: begin
                        if (!pres_found) nx_err = 1'b1;
                        else begin
                            wr_lkset = (op == OP_LOCK_SET);
                            wr_lkclr = (op == OP_LOCK_CLR);
                            wr_way   = pres_idx;
                            nx_way   = pres_idx;
                        end
                    end
                    OP_LOCK_TEST: begin
                        if (!pres_found) nx_err = 1'b1;
                        else begin
                            nx_hit = lk_vld[cset][pres_idx] &&
                                     (lk_ctx[cset][pres_idx] == cmd_ctx);
                            nx_way = pres_idx;
                        end
                    end
                    OP_SET_PERM: begin
                        if (!eq_found || (cmd_perm > 3'd4)) nx_err = 1'b1;
                        else begin
                            wr_perm = 1'b1;
                            wr_way  = eq_idx;
                            nx_way  = eq_idx;
                        end
                    end
                    default: nx_err = 1'b1;            // REJECT
                endcase
            end
        end
    end

    // ---------------- state update ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                line_vld[s] <= '0;
                lk_vld[s]   <= '0;
                for (int w = 0; w < WAYS; w++) begin
                    line_addr[s][w] <= '0;
                    line_perm[s][w] <= PERM_ABSENT;
                    lk_ctx[s][w]    <= '0;
                end
            end
        end else begin
            if (wr_alloc) begin
                line_vld[cset][wr_way]  <= 1'b1;
                line_addr[cset][wr_way] <= cmd_addr;
                line_perm[cset][wr_way] <= PERM_INVAL;
                lk_vld[cset][wr_way]    <= 1'b0;
                lk_ctx[cset][wr_way]    <= '0;
            end
            if (wr_dealloc) begin
                line_vld[cset][wr_way] <= 1'b0;
                lk_vld[cset][wr_way]   <= 1'b0;
            end
            if (wr_lkset) begin
                lk_vld[cset][wr_way] <= 1'b1;
                lk_ctx[cset][wr_way] <= cmd_ctx;
            end
            if (wr_lkclr) lk_vld[cset][wr_way] <= 1'b0;
            if (wr_perm)  line_perm[cset][wr_way] <= perm_e'(cmd_perm);
        end
    end

    // ---------------- response register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid       <= 1'b0;
            rsp_err         <= 1'b0;
            rsp_hit         <= 1'b0;
            rsp_way         <= '0;
            rsp_avail       <= 1'b0;
            rsp_victim_addr <= '0;
            touch_valid     <= 1'b0;
            touch_set       <= '0;
            touch_way       <= '0;
        end else begin
            rsp_valid       <= cmd_valid;
            rsp_err         <= nx_err;
            rsp_hit         <= nx_hit;
            rsp_way         <= nx_way;
            rsp_avail       <= nx_avail;
            rsp_victim_addr <= nx_vaddr;
            touch_valid     <= nx_touch;
            touch_set       <= nx_touch ? cset : '0;
            touch_way       <= nx_tway;
        end
    end

    // ---------------- assertions ----------------
    a_r14_rsp_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> rsp_valid);

    a_r14_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> (!rsp_valid && !touch_valid));

    a_r2_misaligned_rejected: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && misaligned) |=> (rsp_err && !touch_valid && !rsp_hit));

    a_r9_alloc_present_rejected: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !misaligned && op == OP_ALLOC && pres_found) |=> rsp_err);

    a_r11_victim_needs_full_set: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !misaligned && op == OP_VICTIM && set_avail) |=> rsp_err);

    a_r4_store_to_readonly_misses: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !misaligned && op == OP_ACCESS && pres_found &&
         pres_perm == PERM_RDONLY && cmd_req == REQ_STORE)
        |=> (!rsp_hit && touch_valid));

    a_r5_touch_with_response: assert property (@(posedge clk) disable iff (!rst_n)
        touch_valid |-> rsp_valid);

    a_r12_lock_hit_implies_present: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !misaligned && op == OP_LOCK_TEST && !pres_found)
        |=> (rsp_err && !rsp_hit));

endmodule

// File: tb/perm_tag_dir_tb_top.sv
`timescale 1ns/1ps
module perm_tag_dir_tb_top;

    localparam int ADDR_W  = 16;
    localparam int OFF_W   = 4;
    localparam int SETS    = 4;
    localparam int WAYS    = 4;
    localparam int IDX_LSB = 4;
    localparam int CTX_W   = 4;
    localparam int SET_W   = 2;
    localparam int WAY_W   = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [3:0]        cmd_op = '0;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [1:0]        cmd_req = '0;
    logic              cmd_touch = 1'b0;
    logic [CTX_W-1:0]  cmd_ctx = '0;
    logic [2:0]        cmd_perm = '0;
    logic [SET_W-1:0]  pol_set;
    logic [WAY_W-1:0]  pol_victim_way;
    logic              rsp_valid, rsp_err, rsp_hit, rsp_avail, touch_valid;
    logic [WAY_W-1:0]  rsp_way, touch_way;
    logic [SET_W-1:0]  touch_set;
    logic [ADDR_W-1:0] rsp_victim_addr;

    // bench replacement policy: victim = set + 1 (mod WAYS)
    assign pol_victim_way = WAY_W'(pol_set + 2'd1);

    perm_tag_dir #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .SETS(SETS), .WAYS(WAYS),
                   .IDX_LSB(IDX_LSB), .CTX_W(CTX_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_req(cmd_req), .cmd_touch(cmd_touch),
        .cmd_ctx(cmd_ctx), .cmd_perm(cmd_perm), .pol_set(pol_set),
        .pol_victim_way(pol_victim_way), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_hit(rsp_hit), .rsp_way(rsp_way), .rsp_avail(rsp_avail),
        .rsp_victim_addr(rsp_victim_addr), .touch_valid(touch_valid),
        .touch_set(touch_set), .touch_way(touch_way));

    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // reference model state
    bit              m_vld [SETS][WAYS];
    int              m_addr[SETS][WAYS];
    int              m_perm[SETS][WAYS];
    bit              m_lk  [SETS][WAYS];
    int              m_ctx [SETS][WAYS];

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int mk(input int tag, input int set);
        return (tag << (IDX_LSB + SET_W)) | (set << IDX_LSB);
    endfunction

    task automatic issue(input int op, input int addr, input int req, input bit tch,
                         input int ctx, input int perm, input string tag);
        int set, pi, ei, fi, e_way, e_tway, e_tset, e_vaddr, vw;
        bit pf, ef, ff, room, e_err, e_hit, e_avail, e_touch;
        set = (addr >> IDX_LSB) % SETS;
        pf = 0; ef = 0; ff = 0; pi = 0; ei = 0; fi = 0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            bit eq;
            eq = m_vld[set][w] && (m_addr[set][w] == addr);
            if (eq) begin ef = 1; ei = w; end
            if (eq && m_perm[set][w] != 0) begin pf = 1; pi = w; end
            if (!m_vld[set][w] || m_perm[set][w] == 0) begin ff = 1; fi = w; end
        end
        room = ef || ff;
        vw = (set + 1) % WAYS;
        e_err = 0; e_hit = 0; e_avail = 0; e_touch = 0;
        e_way = 0; e_tway = 0; e_tset = 0; e_vaddr = 0;
        if ((addr % (1 << OFF_W)) != 0 || op > 10) e_err = 1;
        else case (op)
            0: begin
                e_hit = pf && (m_perm[set][pi] == 3 || (m_perm[set][pi] == 2 && req <= 1));
                e_way = pi; e_touch = pf; e_tway = pi;
            end
            1: begin e_hit = pf; e_way = pi; end
            2: begin e_hit = ef; e_way = ei; end
            3: e_avail = room;
            4: if (pf || !room) e_err = 1;
               else begin
                   e_way = fi; e_touch = tch; e_tway = tch ? fi : 0;
                   m_vld[set][fi] = 1; m_addr[set][fi] = addr; m_perm[set][fi] = 1;
                   m_lk[set][fi] = 0;
               end
            5: if (!pf) e_err = 1; else begin e_way = pi; m_vld[set][pi] = 0; end
            6: if (room) e_err = 1; else begin e_way = vw; e_vaddr = m_addr[set][vw]; end
            7: if (!pf) e_err = 1; else begin e_way = pi; m_lk[set][pi] = 1; m_ctx[set][pi] = ctx; end
            8: if (!pf) e_err = 1; else begin e_way = pi; m_lk[set][pi] = 0; end
            9: if (!pf) e_err = 1;
               else begin e_way = pi; e_hit = m_lk[set][pi] && m_ctx[set][pi] == ctx; end
            default: if (!ef || perm > 4) e_err = 1;
               else begin e_way = ei; m_perm[set][ei] = perm; end
        endcase
        if (e_touch) e_tset = set;

        cmd_valid = 1'b1; cmd_op = 4'(op); cmd_addr = ADDR_W'(addr); cmd_req = 2'(req);
        cmd_touch = tch; cmd_ctx = CTX_W'(ctx); cmd_perm = 3'(perm);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R14", "rsp_valid", rsp_valid, 1);
        chk(tag, "rsp_err", rsp_err, e_err);
        chk(tag, "rsp_hit", rsp_hit, e_hit);
        chk(tag, "rsp_way", rsp_way, e_way);
        chk(tag, "rsp_avail", rsp_avail, e_avail);
        chk(tag, "rsp_victim_addr", rsp_victim_addr, e_vaddr);
        chk(tag, "touch_valid", touch_valid, e_touch);
        chk(tag, "touch_set", touch_set, e_tset);
        chk(tag, "touch_way", touch_way, e_tway);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                m_vld[s][w] = 0; m_addr[s][w] = 0; m_perm[s][w] = 0;
                m_lk[s][w] = 0; m_ctx[s][w] = 0;
            end
        repeat (3) @(negedge clk);
        chk("R1", "rsp_valid in reset", rsp_valid, 0);
        chk("R1", "touch_valid in reset", touch_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "rsp_valid after reset", rsp_valid, 0);

        // R1: empty directory
        for (int s = 0; s < SETS; s++) begin
            issue(1, mk(1, s), 0, 0, 0, 0, "R1");
            issue(3, mk(1, s), 0, 0, 0, 0, "R1");
            issue(6, mk(1, s), 0, 0, 0, 0, "R11");
        end

        // R2: misaligned and unknown opcodes are rejected without effect
        for (int off = 1; off < (1 << OFF_W); off += 5)
            issue(4, mk(1, 0) | off, 0, 1, 0, 0, "R2");
        for (int op = 11; op < 16; op++) issue(op, mk(1, 0), 0, 1, 0, 0, "R2");
        issue(1, mk(1, 0), 0, 0, 0, 0, "R2");
        issue(3, mk(1, 0), 0, 0, 0, 0, "R2");

        // R8 / R3: fill every set; same tags in every set stay independent
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++)
                issue(4, mk(w + 1, s), 0, bit'(w % 2), 0, 0, "R8");
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                issue(1, mk(w + 1, s), 0, 0, 0, 0, "R3");
                issue(2, mk(w + 1, s), 0, 0, 0, 0, "R6");
            end

        // R7 / R9 / R11 on full sets
        for (int s = 0; s < SETS; s++) begin
            issue(3, mk(9, s), 0, 0, 0, 0, "R7");
            issue(3, mk(2, s), 0, 0, 0, 0, "R7");
            issue(4, mk(9, s), 0, 0, 0, 0, "R9");
            issue(4, mk(2, s), 0, 0, 0, 0, "R9");
            issue(6, mk(9, s), 0, 0, 0, 0, "R11");
        end

        // R4 / R5 / R6 / R13: permission x request sweep on set 1 way 0
        for (int p = 1; p <= 4; p++) begin
            issue(10, mk(1, 1), 0, 0, 0, p, "R13");
            for (int r = 0; r < 3; r++) issue(0, mk(1, 1), r, 0, 0, 0, "R4");
            issue(1, mk(1, 1), 0, 0, 0, 0, "R6");
        end
        issue(10, mk(2, 1), 0, 0, 0, 3, "R13");
        issue(0, mk(2, 1), 2, 0, 0, 0, "R5");
        issue(10, mk(1, 1), 0, 0, 0, 0, "R13");
        for (int r = 0; r < 3; r++) issue(0, mk(1, 1), r, 0, 0, 0, "R5");
        issue(1, mk(1, 1), 0, 0, 0, 0, "R6");
        issue(2, mk(1, 1), 0, 0, 0, 0, "R6");
        issue(3, mk(9, 1), 0, 0, 0, 0, "R7");
        issue(6, mk(9, 1), 0, 0, 0, 0, "R11");
        issue(10, mk(1, 1), 0, 0, 0, 6, "R13");
        issue(10, mk(13, 1), 0, 0, 0, 2, "R13");
        issue(10, mk(1, 1), 0, 0, 0, 0, "R13");
        issue(4, mk(9, 1), 0, 1, 0, 0, "R8");
        issue(2, mk(1, 1), 0, 0, 0, 0, "R6");
        issue(1, mk(9, 1), 0, 0, 0, 0, "R8");

        // R10: deallocate and reuse
        issue(5, mk(2, 2), 0, 0, 0, 0, "R10");
        issue(1, mk(2, 2), 0, 0, 0, 0, "R10");
        issue(5, mk(2, 2), 0, 0, 0, 0, "R10");
        issue(3, mk(12, 2), 0, 0, 0, 0, "R7");
        issue(4, mk(12, 2), 0, 0, 0, 0, "R8");

        // R12: lock ownership
        issue(9, mk(3, 3), 0, 0, 5, 0, "R12");
        issue(7, mk(3, 3), 0, 0, 5, 0, "R12");
        issue(9, mk(3, 3), 0, 0, 5, 0, "R12");
        issue(9, mk(3, 3), 0, 0, 6, 0, "R12");
        issue(7, mk(3, 3), 0, 0, 6, 0, "R12");
        issue(9, mk(3, 3), 0, 0, 6, 0, "R12");
        issue(8, mk(3, 3), 0, 0, 0, 0, "R12");
        issue(9, mk(3, 3), 0, 0, 6, 0, "R12");
        issue(7, mk(14, 3), 0, 0, 1, 0, "R12");
        issue(9, mk(14, 3), 0, 0, 1, 0, "R12");
        issue(8, mk(14, 3), 0, 0, 1, 0, "R12");
        issue(7, mk(4, 3), 0, 0, 7, 0, "R12");
        issue(5, mk(4, 3), 0, 0, 0, 0, "R10");
        issue(4, mk(4, 3), 0, 0, 0, 0, "R8");
        issue(9, mk(4, 3), 0, 0, 7, 0, "R8");
        issue(10, mk(3, 3), 0, 0, 0, 0, "R13");
        issue(7, mk(3, 3), 0, 0, 2, 0, "R12");

        // R14: idle cycle gives no response
        @(negedge clk);
        chk("R14", "idle rsp_valid", rsp_valid, 0);
        chk("R14", "idle touch_valid", touch_valid, 0);

        done = 1'b1;
        finish_run();
    end

endmodule